// File: doc/BRIEF.md
# Flash Array Write-Protection Checker

This block decides whether a program or erase request aimed at a 32-Mbit serial flash array touches the region that the protection bits guard. It takes five protection controls. `cfg_sec` selects whether the protection unit is a 64-kB block or a 4-kB sector. `cfg_tb` anchors the region at the top or the bottom of the array. `cfg_bp` is the three-bit size code. `cfg_cmp` inverts the whole map. Each request also carries a 22-bit start address and a size code.

The block derives the protected address range as an inclusive lower and upper bound. It widens the request to the aligned unit that the request actually covers, then tests the two spans for overlap. A request that overlaps the protected range even partly is flagged, and the command sequencer must then drop it.

All results are registered. The sequencer samples `res_valid`, `res_hit` and the range outputs on the clock edge after the one on which it raised `req_valid`. The bounds hold their value between requests.

Top module: `wp_guard`

## Requirements
- R1: A request presented with `req_valid` high at a clock edge produces `res_valid` high after exactly that edge. With `req_valid` low at an edge, `res_valid` is low after it. Reset (synchronous, active high) clears `res_valid`, `res_hit` and `prot_any`, and sets both bounds to 0.
- R2: With `cfg_cmp`=0 and `cfg_bp`=000, nothing is protected: `prot_any`=0, both bounds are 0 and `res_hit`=0, for any `cfg_sec` and `cfg_tb`. With `cfg_cmp`=0 and `cfg_bp`=111, the whole array 000000h–3FFFFFh is protected for any `cfg_sec` and `cfg_tb`.
- R3: With `cfg_sec`=0, a code n from 1 to 6 protects 64 kB × 2^(n-1), that is 64 kB up to 2 MB.
- R4: With `cfg_sec`=1, codes 1, 2 and 3 protect 4 kB, 8 kB and 16 kB. Codes 4, 5 and 6 each protect 32 kB, so the low code bit has no effect on codes 4 and 5.
- R5: With `cfg_tb`=0, the region of length L runs from 400000h−L to 3FFFFFh. With `cfg_tb`=1, it runs from 000000h to L−1.
- R6: With `cfg_cmp`=1, the reported range is the complement of the range that `cfg_cmp`=0 would give. Code 000 then protects the whole array, and code 111 protects nothing.
- R7: The request size code is 0 for a 256-byte page, 1 for a 4-kB sector, 2 for a 64-kB block and 3 for the whole chip. A request covers the aligned unit that contains its start address; for a chip request the start address has no effect.
- R8: `res_hit` is 1 exactly when the covered span shares at least one address with the protected range. A span that overlaps the range only partly is still flagged.
- R9: A chip request gives `res_hit` equal to `prot_any`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| cfg_sec | input | 1 | Unit select: 0 = 64-kB blocks, 1 = 4-kB sectors |
| cfg_tb | input | 1 | Anchor: 0 = top of array, 1 = bottom |
| cfg_bp | input | 3 | Protection size code |
| cfg_cmp | input | 1 | Invert the protection map |
| req_addr | input | 22 | Request start address |
| req_size | input | 2 | Request size code (see R7) |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | Request touches protected space and must be dropped |
| prot_any | output | 1 | Some part of the array is protected |
| prot_lo | output | 22 | Inclusive lower bound of the protected range |
| prot_hi | output | 22 | Inclusive upper bound of the protected range |

## Verification
The assertions assume that the protection controls and the request fields are stable and defined whenever `req_valid` is high. They make no assumption about those inputs between requests. The stimulus changes every input only on the falling clock edge, and it returns `req_valid` low after each request so that every result is followed by an idle cycle. A full sweep over all 64 protection settings crosses each setting with all four size codes. Each combination is tried at addresses at the bottom of the array, at the top, and just on either side of the region boundaries.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // Request size codes
    typedef enum logic [1:0] {
        REQ_PAGE   = 2'd0,
        REQ_SECTOR = 2'd1,
        REQ_BLOCK  = 2'd2,
        REQ_CHIP   = 2'd3
    } req_size_e;

    // Protection controls as one bundle
    typedef struct packed {
        logic       sec;
        logic       tb;
        logic [2:0] bp;
        logic       cmp;
    } prot_cfg_t;

    localparam int unsigned PAGE_SH   = 8;
    localparam int unsigned SECTOR_SH = 12;
    localparam int unsigned BLOCK_SH  = 16;
    // Largest sector-mode level above the first unit (32 kB = 4 kB << 3)
    localparam int unsigned SECTOR_CAP = 3;

    // log2 of the protected length for size codes 1..6
    function automatic int unsigned region_shift(input logic sec, input logic [2:0] bp);
        int unsigned lvl;
        lvl = int'(bp) - 1;
        if (sec) begin
            if (lvl > SECTOR_CAP) lvl = SECTOR_CAP;
            return SECTOR_SH + lvl;
        end
        return BLOCK_SH + lvl;
    endfunction

    // log2 of the span covered by a request size code
    function automatic int unsigned span_shift(input req_size_e sz);
        case (sz)
            REQ_PAGE:   return PAGE_SH;
            REQ_SECTOR: return SECTOR_SH;
            default:    return BLOCK_SH;
        endcase
    endfunction

endpackage

// File: rtl/wp_region.sv
module wp_region
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W = 22
) (
    input  prot_cfg_t          cfg,
    output logic               any,
    output logic [ADDR_W-1:0]  lo,
    output logic [ADDR_W-1:0]  hi
);
    localparam logic [ADDR_W-1:0] ONE  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] FULL = {ADDR_W{1'b1}};

    logic              base_none, base_all;
    logic [ADDR_W-1:0] len_m1;

    always_comb begin
        base_none = (cfg.bp == 3'b000);
        base_all  = (cfg.bp == 3'b111);
        len_m1    = (ONE << region_shift(cfg.sec, cfg.bp)) - ONE;
        any = 1'b0;
        lo  = '0;
        hi  = '0;
        if (!cfg.cmp) begin
            if (base_all) begin
                any = 1'b1;
                hi  = FULL;
            end else if (!base_none) begin
                any = 1'b1;
                lo  = cfg.tb ? '0     : ~len_m1;
                hi  = cfg.tb ? len_m1 : FULL;
            end
        end else begin
            if (base_none) begin
                any = 1'b1;
                hi  = FULL;
            end else if (!base_all) begin
                // complement of a region anchored at one end is anchored at the other
                any = 1'b1;
                lo  = cfg.tb ? len_m1 + ONE : '0;
                hi  = cfg.tb ? FULL         : ~len_m1 - ONE;
            end
        end
    end
endmodule

// File: rtl/wp_span.sv
module wp_span
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W = 22
) (
    input  logic [ADDR_W-1:0] addr,
    input  req_size_e         size,
    output logic [ADDR_W-1:0] lo,
    output logic [ADDR_W-1:0] hi
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] mask;

    always_comb begin
        mask = (ONE << span_shift(size)) - ONE;
        if (size == REQ_CHIP) begin
            lo = '0;
            hi = {ADDR_W{1'b1}};
        end else begin
            lo = addr & ~mask;
            hi = (addr & ~mask) | mask;
        end
    end
endmodule

// File: rtl/wp_guard.sv
module wp_guard
    import wp_pkg::*;
#(
    parameter int unsigned ADDR_W = 22
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              cfg_sec,
    input  logic              cfg_tb,
    input  logic [2:0]        cfg_bp,
    input  logic              cfg_cmp,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_size,
    output logic              res_valid,
    output logic              res_hit,
    output logic              prot_any,
    output logic [ADDR_W-1:0] prot_lo,
    output logic [ADDR_W-1:0] prot_hi
);
    prot_cfg_t         cfg;
    logic              r_any;
    logic [ADDR_W-1:0] r_lo, r_hi, s_lo, s_hi;
    logic              hit_c;

    assign cfg = '{sec: cfg_sec, tb: cfg_tb, bp: cfg_bp, cmp: cfg_cmp};

    wp_region #(.ADDR_W(ADDR_W)) u_region (
        .cfg (cfg),
        .any (r_any),
        .lo  (r_lo),
        .hi  (r_hi)
    );

    wp_span #(.ADDR_W(ADDR_W)) u_span (
        .addr (req_addr),
        .size (req_size_e'(req_size)),
        .lo   (s_lo),
        .hi   (s_hi)
    );

    assign hit_c = r_any && (s_lo <= r_hi) && (s_hi >= r_lo);

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            prot_any  <= 1'b0;
            prot_lo   <= '0;
            prot_hi   <= '0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_hit  <= hit_c;
                prot_any <= r_any;
                prot_lo  <= r_lo;
                prot_hi  <= r_hi;
            end
        end
    end
endmodule

// File: rtl/wp_guard_chk.sv
module wp_guard_chk #(
    parameter int unsigned ADDR_W = 22
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              cfg_sec,
    input logic              cfg_tb,
    input logic [2:0]        cfg_bp,
    input logic              cfg_cmp,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_size,
    input logic              res_valid,
    input logic              res_hit,
    input logic              prot_any,
    input logic [ADDR_W-1:0] prot_lo,
    input logic [ADDR_W-1:0] prot_hi
);
    // R1
    result_follows_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    // R2
    none_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_bp == 3'b000 && !cfg_cmp) |=> (!prot_any && !res_hit));
    // R2
    all_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_bp == 3'b111 && !cfg_cmp) |=> (res_hit && prot_lo == '0 && prot_hi == {ADDR_W{1'b1}}));
    // R6
    cmp_none_all_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && cfg_bp == 3'b111 && cfg_cmp) |=> !prot_any);
    // R8
    hit_needs_range_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_hit) |-> prot_any);
    // R8
    bounds_ordered_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && prot_any) |-> (prot_lo <= prot_hi));
    // R9
    chip_any_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_size == 2'd3) |=> (res_hit == prot_any));
endmodule

bind wp_guard wp_guard_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_wp_guard.sv
module sim_wp_guard;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 22;
    localparam logic [AW-1:0] TOP = 22'h3FFFFF;

    logic          clk = 1'b0;
    logic          rst;
    logic          req_valid;
    logic          cfg_sec, cfg_tb, cfg_cmp;
    logic [2:0]    cfg_bp;
    logic [AW-1:0] req_addr;
    logic [1:0]    req_size;
    logic          res_valid, res_hit, prot_any;
    logic [AW-1:0] prot_lo, prot_hi;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_guard #(.ADDR_W(AW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid),
        .cfg_sec(cfg_sec), .cfg_tb(cfg_tb), .cfg_bp(cfg_bp), .cfg_cmp(cfg_cmp),
        .req_addr(req_addr), .req_size(req_size),
        .res_valid(res_valid), .res_hit(res_hit), .prot_any(prot_any),
        .prot_lo(prot_lo), .prot_hi(prot_hi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Expected protected length from the size code (R3, R4)
    function automatic logic [AW:0] exp_len(input logic sec, input logic [2:0] bp);
        if (!sec) begin
            case (bp)
                3'd1: return 23'h010000;
                3'd2: return 23'h020000;
                3'd3: return 23'h040000;
                3'd4: return 23'h080000;
                3'd5: return 23'h100000;
                default: return 23'h200000;
            endcase
        end
        case (bp)
            3'd1: return 23'h001000;
            3'd2: return 23'h002000;
            3'd3: return 23'h004000;
            default: return 23'h008000;
        endcase
    endfunction

    // Expected range (R2, R5, R6)
    task automatic exp_range(input logic sec, tb, input logic [2:0] bp, input logic cmp,
                             output logic any, output logic [AW-1:0] lo, hi);
        logic [AW:0] len;
        logic        n_any;
        logic [AW-1:0] n_lo, n_hi;
        len = exp_len(sec, bp);
        if (bp == 3'd0) begin n_any = 0; n_lo = 0; n_hi = 0; end
        else if (bp == 3'd7) begin n_any = 1; n_lo = 0; n_hi = TOP; end
        else if (tb) begin n_any = 1; n_lo = 0; n_hi = AW'(len - 1); end
        else begin n_any = 1; n_lo = AW'(23'h400000 - len); n_hi = TOP; end
        if (!cmp) begin any = n_any; lo = n_lo; hi = n_hi; end
        else if (bp == 3'd0) begin any = 1; lo = 0; hi = TOP; end
        else if (bp == 3'd7) begin any = 0; lo = 0; hi = 0; end
        else if (tb) begin any = 1; lo = AW'(len); hi = TOP; end
        else begin any = 1; lo = 0; hi = AW'(23'h400000 - len - 1); end
    endtask

    // Expected hit (R7, R8, R9)
    function automatic logic exp_hit(input logic any, input logic [AW-1:0] lo, hi,
                                     input logic [AW-1:0] a, input logic [1:0] sz);
        logic [AW-1:0] slo, shi, unit;
        unit = (sz == 2'd0) ? 22'h0000FF : (sz == 2'd1) ? 22'h000FFF : 22'h00FFFF;
        if (sz == 2'd3) begin slo = 0; shi = TOP; end
        else begin slo = a & ~unit; shi = slo | unit; end
        return any && !(shi < lo) && !(slo > hi);
    endfunction

    // One request; result sampled at the falling edge after the capturing edge
    task automatic do_req(input string tag, input logic sec, tb, input logic [2:0] bp,
                          input logic cmp, input logic [AW-1:0] a, input logic [1:0] sz);
        logic any_e;
        logic [AW-1:0] lo_e, hi_e;
        exp_range(sec, tb, bp, cmp, any_e, lo_e, hi_e);
        cfg_sec = sec; cfg_tb = tb; cfg_bp = bp; cfg_cmp = cmp;
        req_addr = a; req_size = sz; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk({tag, " R1 valid"}, 32'(res_valid), 32'd1);
        chk({tag, " any"}, 32'(prot_any), 32'(any_e));
        chk({tag, " lo"}, 32'(prot_lo), 32'(lo_e));
        chk({tag, " hi"}, 32'(prot_hi), 32'(hi_e));
        chk({tag, " hit"}, 32'(res_hit), 32'(exp_hit(any_e, lo_e, hi_e, a, sz)));
        @(negedge clk);
        chk({tag, " R1 idle"}, 32'(res_valid), 32'd0);
    endtask

    task automatic t_reset;
        chk("R1 reset valid", 32'(res_valid), 32'd0);
        chk("R1 reset hit", 32'(res_hit), 32'd0);
        chk("R1 reset any", 32'(prot_any), 32'd0);
        chk("R1 reset lo", 32'(prot_lo), 32'd0);
        chk("R1 reset hi", 32'(prot_hi), 32'd0);
    endtask

    task automatic t_none_all;
        do_req("R2 none top", 1, 0, 3'd0, 0, TOP, 2'd2);
        chk("R2 none hit", 32'(res_hit), 32'd0);
        do_req("R2 all", 1, 1, 3'd7, 0, 22'h123456, 2'd0);
        chk("R2 all hi", 32'(prot_hi), 32'h3FFFFF);
    endtask

    task automatic t_blocks;
        do_req("R3 R5 one block top", 0, 0, 3'd1, 0, 22'h3F0000, 2'd0);
        chk("R3 lo 3F0000", 32'(prot_lo), 32'h3F0000);
        chk("R3 hit", 32'(res_hit), 32'd1);
        do_req("R3 R5 half bottom", 0, 1, 3'd6, 0, 22'h200000, 2'd2);
        chk("R5 hi 1FFFFF", 32'(prot_hi), 32'h1FFFFF);
        chk("R5 no hit", 32'(res_hit), 32'd0);
    endtask

    task automatic t_sectors;
        do_req("R4 8k bottom", 1, 1, 3'd2, 0, 22'h001F00, 2'd0);
        chk("R4 hi 1FFF", 32'(prot_hi), 32'h001FFF);
        do_req("R4 code4 top", 1, 0, 3'd4, 0, 22'h3F8000, 2'd1);
        chk("R4 lo 3F8000", 32'(prot_lo), 32'h3F8000);
        do_req("R4 code5 top", 1, 0, 3'd5, 0, 22'h3F7000, 2'd1);
        chk("R4 bp0 ignored lo", 32'(prot_lo), 32'h3F8000);
        chk("R4 below no hit", 32'(res_hit), 32'd0);
    endtask

    task automatic t_cmp;
        do_req("R6 top sector freed", 1, 0, 3'd1, 1, 22'h3FF000, 2'd1);
        chk("R6 hi 3FEFFF", 32'(prot_hi), 32'h3FEFFF);
        chk("R6 free sector", 32'(res_hit), 32'd0);
        do_req("R6 page below", 1, 0, 3'd1, 1, 22'h3FEF80, 2'd0);
        chk("R6 page hit", 32'(res_hit), 32'd1);
        do_req("R6 code0 all", 0, 1, 3'd0, 1, 22'h000000, 2'd0);
        chk("R6 code0 hit", 32'(res_hit), 32'd1);
        do_req("R6 code7 none", 0, 0, 3'd7, 1, 22'h000000, 2'd3);
        chk("R6 code7 any", 32'(prot_any), 32'd0);
    endtask

    task automatic t_partial;
        do_req("R8 R7 block over 4k", 1, 1, 3'd1, 0, 22'h00F123, 2'd2);
        chk("R8 partial hit", 32'(res_hit), 32'd1);
        do_req("R7 page after", 1, 1, 3'd1, 0, 22'h0010FF, 2'd0);
        chk("R7 page clear", 32'(res_hit), 32'd0);
        do_req("R7 page inside", 1, 1, 3'd1, 0, 22'h000FFF, 2'd0);
        chk("R7 edge hit", 32'(res_hit), 32'd1);
    endtask

    task automatic t_chip;
        do_req("R9 chip protected", 1, 0, 3'd1, 0, 22'h000000, 2'd3);
        chk("R9 chip hit", 32'(res_hit), 32'd1);
        do_req("R9 chip clear", 0, 0, 3'd0, 0, TOP, 2'd3);
        chk("R9 chip no hit", 32'(res_hit), 32'd0);
    endtask

    task automatic t_sweep;
        logic [AW-1:0] addrs [6] = '{22'h000000, 22'h0FFFFF, 22'h1FF0FF, 22'h200000, 22'h3F7F00, 22'h3FFFFF};
        for (int c = 0; c < 64; c++) begin
            for (int s = 0; s < 4; s++) begin
                for (int k = 0; k < 6; k++) begin
                    do_req("R8 sweep", c[5], c[4], c[3:1], c[0], addrs[k], 2'(s));
                end
            end
        end
    endtask

    initial begin
        rst = 1'b1; req_valid = 0; cfg_sec = 0; cfg_tb = 0; cfg_bp = 0; cfg_cmp = 0;
        req_addr = 0; req_size = 0;
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_none_all;
        t_blocks;
        t_sectors;
        t_cmp;
        t_partial;
        t_chip;
        t_sweep;
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule